// File: doc/BRIEF.md
# Multi-Mode 8-bit Barrel Shifter

This block moves an 8-bit word by 0 to 7 positions in a single clock cycle. A 3-bit function code selects one of six kinds of shift:

- logical shifts in either direction;
- arithmetic shifts in either direction;
- rotates in either direction.

The shift distance comes in on its own 3-bit input. The combinational path is a chain of log-stage multiplexers. The result is captured in an output register on the rising clock edge, so a caller sees the answer one edge after it presents the operands.

Left-going operations reuse the right-going datapath. The word is bit-reversed before the multiplexers and reversed again after them. For the arithmetic left case, a final fix-up puts the original sign bit back into the top bit.

Top module: `barrel_shift8`

## Requirements
- R1: With `rst` high at a rising edge, `dout` is 0 after that edge (synchronous, active-high reset).
- R2: The result for the operands present at a rising edge appears on `dout` after that edge. `dout` holds it until the next edge.
- R3: A shift amount of 0 passes `din` to `dout` unchanged, for every function code.
- R4: Code 000 (bit 2 = direction, 0 right; bit 1 = rotate; bit 0 = arithmetic) is a logical right shift, with zeros entering at bit 7.
- R5: Code 001 is an arithmetic right shift: vacated high bits take the value of the original bit 7.
- R6: Codes 010 and 011 are both a rotate right; bit 0 of the code is ignored.
- R7: Code 100 is a logical left shift, with zeros entering at bit 0.
- R8: Code 101 is an arithmetic left shift. It gives the logical left result, except that bit 7 keeps the original bit 7.
- R9: Codes 110 and 111 are both a rotate left; bit 0 of the code is ignored.
- R10: When `rst` is high in the same cycle as a valid operation, the reset wins and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Word to be shifted |
| amt | input | 3 | Shift distance, 0 to 7 |
| func | input | 3 | Shift kind: direction, rotate, arithmetic |
| dout | output | 8 | Registered result |

## Verification
Reset and the capture of a new shift result both act on the output register at the same edge. The bench sets up a nonzero arithmetic-right operation and raises `rst` in that same cycle. It expects zero, which shows the reset has priority. It then drops reset with the operands unchanged and expects the shifted value on the next edge. A further check changes the operands between edges and confirms the output still holds the previous answer until the clock rises.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  // Function code layout: {left, rotate, arith}
  typedef struct packed {
    logic left;
    logic rotate;
    logic arith;
  } bsh_op_t;
endpackage

// File: rtl/bsh_stage.sv
// One log stage: conditionally moves the word right by DIST places.
module bsh_stage #(
  parameter int W    = 8,
  parameter int DIST = 1
) (
  input  logic [W-1:0] d_in,
  input  logic         en,
  input  logic         rotate,
  input  logic         fill,
  output logic [W-1:0] d_out
);
  logic [W-1:0] moved;

  always_comb begin
    if (rotate) moved = {d_in[DIST-1:0], d_in[W-1:DIST]};
    else        moved = {{DIST{fill}}, d_in[W-1:DIST]};
    d_out = en ? moved : d_in;
  end
endmodule

// File: rtl/bsh_core.sv
// Combinational shifter: reverse for left moves, log stages, reverse back.
module bsh_core
  import bsh_pkg::*;
#(
  parameter int W     = 8,
  parameter int AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     din,
  input  logic [AMT_W-1:0] amt,
  input  bsh_op_t          op,
  output logic [W-1:0]     res
);
  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic [W-1:0] lvl [AMT_W+1];
  logic         fill_bit;

  generate
    for (genvar i = 0; i < W; i++) begin : g_rev_in
      assign rev_in[i] = din[W-1-i];
    end
  endgenerate

  // Sign fill only for the arithmetic right case; every other case fills with 0.
  assign fill_bit = !op.left && !op.rotate && op.arith && din[W-1];
  assign lvl[0]   = op.left ? rev_in : din;

  generate
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
      bsh_stage #(.W(W), .DIST(1 << k)) u_stage (
        .d_in  (lvl[k]),
        .en    (amt[k]),
        .rotate(op.rotate),
        .fill  (fill_bit),
        .d_out (lvl[k+1])
      );
    end
    for (genvar i = 0; i < W; i++) begin : g_rev_out
      assign rev_out[i] = lvl[AMT_W][W-1-i];
    end
  endgenerate

  always_comb begin
    res = op.left ? rev_out : lvl[AMT_W];
    if (op.left && !op.rotate && op.arith) res[W-1] = din[W-1];
  end
endmodule

// File: rtl/barrel_shift8.sv
module barrel_shift8
  import bsh_pkg::*;
#(
  parameter int W     = 8,
  parameter int AMT_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     din,
  input  logic [AMT_W-1:0] amt,
  input  logic [2:0]       func,
  output logic [W-1:0]     dout
);
  bsh_op_t      op;
  logic [W-1:0] res_c;

  assign op = bsh_op_t'(func);

  bsh_core #(.W(W), .AMT_W(AMT_W)) u_core (
    .din(din),
    .amt(amt),
    .op (op),
    .res(res_c)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= res_c;
  end

  // R1 / R10: a reset cycle leaves zero behind
  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dout == '0);

  // R3: zero distance passes data unchanged
  assert_zero_amt_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(amt) == '0) |-> dout == $past(din));

  // R4: logical right with nonzero distance clears the top bit
  assert_lsr_top_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(func) == 3'b000 && $past(amt) != '0) |-> !dout[W-1]);

  // R5: arithmetic right keeps the sign
  assert_asr_sign_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(func) == 3'b001) |-> dout[W-1] == $past(din[W-1]));

  // R6 / R9: rotates preserve the count of ones
  assert_rot_popcount_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(func[1])) |-> $countones(dout) == $countones($past(din)));

  // R7: logical left with nonzero distance clears the bottom bit
  assert_lsl_low_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(func) == 3'b100 && $past(amt) != '0) |-> !dout[0]);

  // R8: arithmetic left keeps the sign
  assert_asl_sign_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(func) == 3'b101) |-> dout[W-1] == $past(din[W-1]));
endmodule

// File: tb/tb_barrel_shift8.sv
module tb_barrel_shift8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = '0;
  logic [2:0] amt = '0;
  logic [2:0] func = '0;
  logic [7:0] dout;
  int total = 0;
  int fails = 0;

  always #10 clk = ~clk; // 50 MHz

  barrel_shift8 dut (.clk(clk), .rst(rst), .din(din), .amt(amt), .func(func), .dout(dout));

  // {req, func, amt, din, expected}
  localparam int NV = 15;
  localparam logic [25:0] VEC [NV] = '{
    {4'd4, 3'b000, 3'd3, 8'hB6, 8'h16}, // R4
    {4'd4, 3'b000, 3'd7, 8'hFF, 8'h01}, // R4
    {4'd5, 3'b001, 3'd3, 8'hB6, 8'hF6}, // R5
    {4'd5, 3'b001, 3'd2, 8'h56, 8'h15}, // R5
    {4'd5, 3'b001, 3'd7, 8'h80, 8'hFF}, // R5
    {4'd6, 3'b010, 3'd1, 8'h81, 8'hC0}, // R6
    {4'd6, 3'b011, 3'd4, 8'h3C, 8'hC3}, // R6 low bit ignored
    {4'd7, 3'b100, 3'd2, 8'h5B, 8'h6C}, // R7
    {4'd7, 3'b100, 3'd7, 8'hFF, 8'h80}, // R7
    {4'd8, 3'b101, 3'd2, 8'hD3, 8'hCC}, // R8
    {4'd8, 3'b101, 3'd1, 8'h41, 8'h02}, // R8
    {4'd8, 3'b101, 3'd7, 8'h7F, 8'h00}, // R8
    {4'd9, 3'b110, 3'd3, 8'hA5, 8'h2D}, // R9
    {4'd9, 3'b111, 3'd7, 8'h01, 8'h80}, // R9 low bit ignored
    {4'd9, 3'b111, 3'd1, 8'h80, 8'h01}  // R9
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    total++;
    if (dout !== exp) begin
      fails++;
      $display("FAIL %s: dout=%02h expected=%02h", req, dout, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: dout=%02h expected=finished run", dout);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    din = 8'hB6; amt = 3'd3; func = 3'b001;
    tick();
    check("R1", 8'h00);
    // R10: reset together with a valid operation
    check("R10", 8'h00);
    rst = 1'b0;
    tick();
    check("R10", 8'hF6);

    for (int i = 0; i < NV; i++) begin
      {func, amt, din} = VEC[i][21:8];
      tick();
      check($sformatf("R%0d", VEC[i][25:22]), VEC[i][7:0]);
    end

    // R3: zero distance for every code
    for (int c = 0; c < 8; c++) begin
      func = 3'(c); amt = 3'd0; din = 8'hA7;
      tick();
      check("R3", 8'hA7);
    end

    // R2: output holds until the next rising edge
    func = 3'b000; amt = 3'd1; din = 8'h80;
    tick();
    check("R2", 8'h40);
    din = 8'h02;
    #5;
    check("R2", 8'h40);
    tick();
    check("R2", 8'h01);

    // R1: mid-run reset
    rst = 1'b1;
    tick();
    check("R1", 8'h00);
    rst = 1'b0;
    tick();
    check("R1", 8'h01);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule